// File: doc/BRIEF.md
# Receiver Sample Concealment and Error Flag

This block sits behind the frame decoder of a digital audio receiver. Each decoded sample arrives with a parity status, the validity bit, the emphasis bit and a two-bit rate code. A separate level input reports loss of lock, which the decoder derives from its preamble search. The block repairs each sample and passes it on. A short run of parity failures repeats the last good word. A long run mutes the output. Loss of lock zeroes the sample and forces the rate code to its error value. The block also drives an error flag. The flag rises at once on any fault and is released only after a long stretch of clean frames.

Samples enter and leave on valid/ready handshakes through a single register stage. An input sample is taken when `in_valid` and `in_ready` are both high, and `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output sample is held unchanged and no new sample is taken. The release delay is counted in accepted frames rather than clock cycles. The delay in time therefore scales inversely with the sample rate; the default of 12288 frames gives about a quarter second at 48 kHz.

Top module: `rx_conceal`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `err_flag` is 1, `out_rate` is the error code 2'b10, and `out_audio`, `out_validity` and `out_emph` are 0.
- R2: A sample accepted with no parity error and no lock error appears one cycle later with its audio word, rate code, validity and emphasis unchanged. The rate codes are 2'b11 for 32 kHz, 2'b00 for 44.1 kHz, 2'b01 for 48 kHz and 2'b10 for error.
- R3: For the 1st to the HOLD_MAX-th (default 8) consecutive accepted samples with a parity error, `out_audio` repeats the last good audio word.
- R4: From the (HOLD_MAX+1)-th consecutive parity error onward, `out_audio` is zero.
- R5: A sample with a parity error leaves `out_rate`, `out_validity` and `out_emph` at their current values.
- R6: A single good sample clears the consecutive-error count. The next parity error then repeats that good sample.
- R7: A sample accepted while `lock_err` is high gives `out_audio` 0, `out_rate` 2'b10, `out_validity` 0 and `out_emph` 0. The repeat value for later parity errors becomes zero.
- R8: `err_flag` is 1 in the cycle after `lock_err` is high in any cycle, or after a parity-error sample is accepted.
- R9: `err_flag` falls after RELEASE_FRAMES consecutive clean accepted samples. Any new error restarts that count.
- R10: While `out_rate` is 2'b10, `out_audio` and `out_emph` are 0. This holds even for a good sample whose rate code is 2'b10.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output sample stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_err | input | 1 | Lock lost, from preamble detection (level) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take an input sample |
| in_audio | input | AUDIO_W | Decoded audio word |
| in_parity_err | input | 1 | Parity failed for this sample |
| in_validity | input | 1 | Validity bit of this sample |
| in_rate | input | 2 | Rate code of this sample |
| in_emph | input | 1 | Emphasis bit of this sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output sample |
| out_audio | output | AUDIO_W | Concealed audio word |
| out_rate | output | 2 | Gated rate code |
| out_validity | output | 1 | Gated validity flag |
| out_emph | output | 1 | Gated emphasis flag |
| err_flag | output | 1 | Error indication with release hysteresis |

## Verification
The assertions check several properties on every cycle:
- muting and code forcing after a lock-error sample;
- rate, validity and emphasis holding across a parity-error sample;
- the error-code gating of audio and emphasis;
- output stability under back-pressure;
- the flag rising after any fault;
- the saturation bound on the error-run counter.

Other behaviours can only be shown by the bench's scenarios, because they depend on history over many samples:
- which word is repeated;
- the exact switch from hold to mute at the ninth error;
- the count reset by one good sample;
- the exact frame on which the flag is released, with and without a restart.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef logic [1:0] rate_t;
  localparam rate_t RATE_32K  = 2'b11;
  localparam rate_t RATE_44K1 = 2'b00;
  localparam rate_t RATE_48K  = 2'b01;
  localparam rate_t RATE_ERR  = 2'b10;
endpackage

// File: rtl/rxc_run_ctr.sv
// Counts consecutive parity-failed samples, saturating one past the hold limit.
module rxc_run_ctr #(
  parameter int HOLD_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_evt,   // accepted sample with parity failure, lock good
  input  logic clr_evt,   // accepted good sample or lock error
  output logic hold_ok    // this bad sample is still within the hold window
);
  localparam int CW = $clog2(HOLD_MAX + 2);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_MAX);
  localparam logic [CW-1:0] SAT   = CW'(HOLD_MAX + 1);

  logic [CW-1:0] run_q;

  assign hold_ok = (run_q < LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr_evt) begin
      run_q <= '0;
    end else if (bad_evt && run_q != SAT) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R4: run count never exceeds the saturation point
  p_run_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SAT);
  // R6: a clear always empties the run
  p_run_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> run_q == '0);
endmodule

// File: rtl/rxc_release.sv
// Error flag with release after a number of clean frames.
module rxc_release #(
  parameter int FRAMES = 12288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic clean_evt,
  output logic err_flag
);
  localparam int CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LOAD = CW'(FRAMES);

  logic [CW-1:0] left_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      left_q <= LOAD;
    end else if (err_evt) begin
      flag_q <= 1'b1;
      left_q <= LOAD;
    end else if (clean_evt && flag_q) begin
      if (left_q == 1) begin
        flag_q <= 1'b0;
        left_q <= '0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign err_flag = flag_q;

  // R8: any fault raises the flag on the next cycle
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_flag);
  // R9: the flag can only fall on a clean frame
  p_flag_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(clean_evt));
endmodule

// File: rtl/rx_conceal.sv
module rx_conceal
  import rxc_pkg::*;
#(
  parameter int AUDIO_W        = 20,
  parameter int HOLD_MAX       = 8,
  parameter int RELEASE_FRAMES = 12288
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_err,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [AUDIO_W-1:0] in_audio,
  input  logic               in_parity_err,
  input  logic               in_validity,
  input  logic [1:0]         in_rate,
  input  logic               in_emph,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [AUDIO_W-1:0] out_audio,
  output logic [1:0]         out_rate,
  output logic               out_validity,
  output logic               out_emph,
  output logic               err_flag
);
  logic               acc, bad_evt, good_evt, rate_mute, hold_ok;
  logic [AUDIO_W-1:0] last_good_q;

  assign in_ready  = !out_valid || out_ready;
  assign acc       = in_valid && in_ready;
  assign bad_evt   = acc && in_parity_err && !lock_err;
  assign good_evt  = acc && !in_parity_err && !lock_err;
  assign rate_mute = (in_rate == RATE_ERR);

  rxc_run_ctr #(.HOLD_MAX(HOLD_MAX)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .bad_evt (bad_evt),
    .clr_evt (good_evt || (acc && lock_err)),
    .hold_ok (hold_ok)
  );

  rxc_release #(.FRAMES(RELEASE_FRAMES)) u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_evt   (lock_err || bad_evt),
    .clean_evt (good_evt),
    .err_flag  (err_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_audio    <= '0;
      out_rate     <= RATE_ERR;
      out_validity <= 1'b0;
      out_emph     <= 1'b0;
      last_good_q  <= '0;
    end else begin
      if (acc)            out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;

      if (acc) begin
        if (lock_err) begin
          out_audio    <= '0;
          out_rate     <= RATE_ERR;
          out_validity <= 1'b0;
          out_emph     <= 1'b0;
          last_good_q  <= '0;
        end else if (in_parity_err) begin
          out_audio <= hold_ok ? last_good_q : '0;
        end else begin
          out_audio    <= rate_mute ? '0 : in_audio;
          last_good_q  <= rate_mute ? '0 : in_audio;
          out_rate     <= in_rate;
          out_validity <= in_validity;
          out_emph     <= rate_mute ? 1'b0 : in_emph;
        end
      end
    end
  end

  // R7: lock-error sample is muted and carries the error code
  p_lock_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lock_err |=> out_audio == '0 && out_rate == RATE_ERR
                        && !out_validity && !out_emph);
  // R5: parity failure keeps side information
  p_par_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> $stable(out_rate) && $stable(out_validity) && $stable(out_emph));
  // R10: error rate code gates audio and emphasis
  p_err_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_rate == RATE_ERR |-> out_audio == '0 && !out_emph);
  // R11: stalled output holds
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_audio)
                                && $stable(out_rate) && $stable(out_validity));
  // R2: a good sample shows up in the next cycle
  p_good_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    good_evt |=> out_valid && out_rate == $past(in_rate));
endmodule

// File: tb/rx_conceal_bench.sv
module rx_conceal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int REL = 6;

  logic clk = 0, rst_n = 0;
  logic lock_err = 0, in_valid = 0, in_parity_err = 0, in_validity = 0, in_emph = 0;
  logic out_ready = 1;
  logic [W-1:0] in_audio = '0;
  logic [1:0] in_rate = 2'b00;
  logic in_ready, out_valid, out_validity, out_emph, err_flag;
  logic [W-1:0] out_audio;
  logic [1:0] out_rate;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_conceal #(.AUDIO_W(W), .HOLD_MAX(8), .RELEASE_FRAMES(REL)) u_rx_conceal (
    .clk(clk), .rst_n(rst_n), .lock_err(lock_err), .in_valid(in_valid),
    .in_ready(in_ready), .in_audio(in_audio), .in_parity_err(in_parity_err),
    .in_validity(in_validity), .in_rate(in_rate), .in_emph(in_emph),
    .out_valid(out_valid), .out_ready(out_ready), .out_audio(out_audio),
    .out_rate(out_rate), .out_validity(out_validity), .out_emph(out_emph),
    .err_flag(err_flag));

  typedef struct packed {
    logic lk; logic pe; logic [W-1:0] a; logic [1:0] r; logic v; logic e;
    logic [W-1:0] xa; logic [1:0] xr; logic xv; logic xe;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{1'b0,1'b0,20'h12345,2'b01,1'b1,1'b1, 20'h12345,2'b01,1'b1,1'b1}, // R2
    '{1'b0,1'b1,20'hFFFFF,2'b11,1'b0,1'b0, 20'h12345,2'b01,1'b1,1'b1}, // R3 R5
    '{1'b0,1'b0,20'h00ABC,2'b00,1'b0,1'b0, 20'h00ABC,2'b00,1'b0,1'b0}, // R2
    '{1'b0,1'b1,20'h11111,2'b01,1'b1,1'b1, 20'h00ABC,2'b00,1'b0,1'b0}, // R5
    '{1'b0,1'b0,20'h80000,2'b11,1'b1,1'b0, 20'h80000,2'b11,1'b1,1'b0}, // R2
    '{1'b1,1'b0,20'h55555,2'b01,1'b1,1'b1, 20'h00000,2'b10,1'b0,1'b0}, // R7
    '{1'b0,1'b1,20'h22222,2'b01,1'b1,1'b1, 20'h00000,2'b10,1'b0,1'b0}, // R7 R10
    '{1'b0,1'b0,20'h7FFFF,2'b01,1'b1,1'b1, 20'h7FFFF,2'b01,1'b1,1'b1}, // R2
    '{1'b0,1'b0,20'h11111,2'b10,1'b1,1'b1, 20'h00000,2'b10,1'b1,1'b0}, // R10
    '{1'b0,1'b1,20'h33333,2'b00,1'b0,1'b1, 20'h00000,2'b10,1'b1,1'b0}, // R10
    '{1'b0,1'b0,20'h00001,2'b00,1'b1,1'b0, 20'h00001,2'b00,1'b1,1'b0}  // R2
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, advance to the next falling edge
  task automatic send(input logic lk, input logic pe, input logic [W-1:0] a,
                      input logic [1:0] r, input logic v, input logic e);
    in_valid = 1; lock_err = lk; in_parity_err = pe; in_audio = a;
    in_rate = r; in_validity = v; in_emph = e;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 0; lock_err = 0; in_parity_err = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 out_valid", W'(out_valid), W'(0));
    chk("R1 in_ready", W'(in_ready), W'(1));
    chk("R1 err_flag", W'(err_flag), W'(1));
    chk("R1 out_rate", W'(out_rate), W'(2'b10));
    chk("R1 out_audio", out_audio, '0);

    for (int i = 0; i < 11; i++) begin
      send(TBL[i].lk, TBL[i].pe, TBL[i].a, TBL[i].r, TBL[i].v, TBL[i].e);
      chk("R2/R5/R7/R10 table audio", out_audio, TBL[i].xa);
      chk("R2/R5/R7/R10 table rate", W'(out_rate), W'(TBL[i].xr));
      chk("R2/R5/R7 table validity", W'(out_validity), W'(TBL[i].xv));
      chk("R2/R5/R7/R10 table emph", W'(out_emph), W'(TBL[i].xe));
    end

    // R3 / R4: hold for 8, mute from the 9th
    send(0, 0, 20'h0ABCD, 2'b01, 1, 0);
    for (int k = 1; k <= 10; k++) begin
      send(0, 1, 20'hDEAD0, 2'b11, 0, 1);
      if (k <= 8) chk("R3 hold", out_audio, 20'h0ABCD);
      else        chk("R4 mute", out_audio, 20'h00000);
    end
    chk("R5 rate after run", W'(out_rate), W'(2'b01));
    chk("R5 validity after run", W'(out_validity), W'(1));

    // R6: one good sample clears the run
    send(0, 0, 20'h00321, 2'b00, 1, 0);
    send(0, 1, 20'h99999, 2'b00, 1, 0);
    chk("R6 held after clear", out_audio, 20'h00321);

    // R9: release after REL clean frames, restart on error
    for (int k = 0; k < REL - 1; k++) send(0, 0, W'(k), 2'b00, 1, 0);
    chk("R9 still high", W'(err_flag), W'(1));
    send(0, 1, 20'h0, 2'b00, 1, 0);
    for (int k = 0; k < REL - 1; k++) send(0, 0, W'(k), 2'b00, 1, 0);
    chk("R9 restart still high", W'(err_flag), W'(1));
    send(0, 0, 20'h00777, 2'b00, 1, 0);
    chk("R9 released", W'(err_flag), W'(0));

    // R8: lock error with no sample raises flag
    in_valid = 0; lock_err = 1;
    @(negedge clk);
    chk("R8 flag on lock", W'(err_flag), W'(1));
    lock_err = 0;
    for (int k = 0; k < REL; k++) send(0, 0, W'(k+1), 2'b00, 1, 0);
    chk("R9 released again", W'(err_flag), W'(0));
    send(0, 1, 20'h0, 2'b00, 1, 0);
    chk("R8 flag on parity", W'(err_flag), W'(1));

    // R11: back-pressure
    idle();
    out_ready = 0;
    send(0, 0, 20'h0AAAA, 2'b01, 1, 0);
    chk("R11 first out", out_audio, 20'h0AAAA);
    chk("R11 ready low", W'(in_ready), W'(0));
    send(0, 0, 20'h0BBBB, 2'b00, 0, 0);
    chk("R11 stalled stable", out_audio, 20'h0AAAA);
    chk("R11 still valid", W'(out_valid), W'(1));
    out_ready = 1;
    #1;
    chk("R11 ready follows", W'(in_ready), W'(1));
    @(negedge clk);
    chk("R11 next out", out_audio, 20'h0BBBB);
    idle();
    chk("R11 drained", W'(out_valid), W'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule